// File: doc/BRIEF.md
# Primary Clock Failure Guard

This block supervises the primary system clock against a slow, always-running watchdog oscillator. It counts watchdog-clock ticks between pieces of evidence that the primary clock is alive. When too many ticks pass without that evidence, it declares the primary clock dead. It then moves the system clock onto the watchdog oscillator on its own, raises a sticky failure flag and emits a one-cycle event. An interrupt controller can turn that event into a non-maskable request, so recovery software can run at the slow clock.

The evidence of life comes from a heartbeat loop. A request bit in the watchdog domain is synchronised into the primary domain, echoed back through a second synchroniser, and each returned edge counts as one beat. The default miss limit is 12 reference ticks. With a reference clock near 10 kHz, that puts the threshold close to 1 kHz, with wide tolerance.

The system clock comes from a break-before-make clock switch. If the primary clock has stopped, the switch would wait for it forever, so a declared failure clears the primary side of the switch directly. All control inputs are synchronous to `wdt_clk_i`. Software is expected to turn detection off around a source change. A source write also holds the miss counter until the switch handshake completes.

The controller has four states:
- ST_OFF (disarmed)
- ST_WATCH (counting missed beats)
- ST_SWITCH (a source change is in flight)
- ST_FAILED (the sticky failure state)

Its transitions are:
- OFF→WATCH when armed.
- OFF, WATCH or SWITCH→SWITCH on a source write.
- WATCH→OFF when disarmed.
- WATCH→FAILED when MISS_LIMIT ticks pass without a beat.
- SWITCH→OFF when the handshake completes or MISS_LIMIT ticks pass.
- FAILED→OFF on a clear.

"Armed" means detection is enabled, the watchdog oscillator is enabled, no watchdog oscillator failure is flagged, and the primary (source code 0) is selected.

Top module: `clk_fail_guard`

## Requirements
- R1: During and after reset, `fail_o` and `fail_evt_o` are low, the source select is primary (code 0), and `sys_clk_o` follows `pri_clk_i`.
- R2: While armed with a running primary clock, `fail_o` never rises.
- R3: When armed and the primary clock stops, `fail_o` rises no earlier than MISS_LIMIT reference cycles and no later than MISS_LIMIT+12 reference cycles after the stop.
- R4: Each entry into failure produces exactly one `fail_evt_o` pulse, one reference cycle wide, in the cycle where `fail_o` rises.
- R5: While `fail_o` is high, `sys_clk_o` follows `wdt_clk_i`, even when the primary clock has stopped or has resumed.
- R6: `fail_o` stays high until `fail_clr_i` is sampled high. After the clear, `sys_clk_o` returns to the selected source.
- R7: With `det_en_i` low, a stopped primary clock never raises `fail_o`.
- R8: With `wdt_en_i` low, a stopped primary clock neither raises `fail_o` nor moves the clock.
- R9: With the watchdog oscillator selected as the source (`src_sel_i`=1 written), detection stays off.
- R10: While `wdt_fail_i` is high, primary clock failure is not detected.
- R11: A source write moves `sys_clk_o` to the new source within 12 reference cycles. The switch is glitch-free: `sys_clk_o` never has a high or low phase shorter than half a period of the faster clock, and the two sides of the switch are never enabled together.
- R12: A primary clock pause of a few reference cycles, well below MISS_LIMIT, does not raise `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk_i | input | 1 | Primary oscillator clock |
| wdt_clk_i | input | 1 | Watchdog oscillator clock; reference and control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdt_en_i | input | 1 | Watchdog oscillator enabled |
| det_en_i | input | 1 | Primary failure detection enable |
| wdt_fail_i | input | 1 | Watchdog oscillator failure already flagged |
| src_sel_i | input | 1 | Source code to write: 0 primary, 1 watchdog oscillator |
| src_wr_i | input | 1 | Write strobe for `src_sel_i` |
| fail_clr_i | input | 1 | Clears the sticky failure flag |
| sys_clk_o | output | 1 | Switched system clock |
| fail_o | output | 1 | Sticky primary failure flag |
| fail_evt_o | output | 1 | One-cycle failure event |

## Verification
The hardest situation to reach is a failure in which the primary clock has truly stopped. In that case the clock switch cannot finish its handshake, and only the forced path can move the clock. The bench holds the primary clock generator low for tens of reference cycles, and then checks at mid-phase sample points that the system clock tracks the watchdog clock. A constrained random loop mixes short pauses below the threshold with long stops under random arming conditions. It also watches every system clock edge for a shortened phase.

// File: rtl/clk_fail_guard_pkg.sv
`timescale 1ns/1ps
package clk_fail_guard_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WATCH  = 2'd1,
        ST_SWITCH = 2'd2,
        ST_FAILED = 2'd3
    } guard_state_t;

    localparam logic SRC_PRI = 1'b0;
    localparam logic SRC_WDT = 1'b1;

endpackage

// File: rtl/cfm_heartbeat.sv
`timescale 1ns/1ps
// Round-trip liveness loop: a request level crosses into the primary domain,
// is echoed back, and each returned echo edge is one beat in the reference domain.
module cfm_heartbeat #(
    parameter int SYNC_STAGES = 2
) (
    input  logic pri_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic beat
);
    localparam int ECHO_W = SYNC_STAGES + 1;

    logic                   req_q;
    logic [SYNC_STAGES-1:0] pri_sh;
    logic [ECHO_W-1:0]      echo_sh;

    // primary domain: carry the request across
    always_ff @(posedge pri_clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_sh <= '0;
        end else begin
            pri_sh <= {pri_sh[SYNC_STAGES-2:0], req_q};
        end
    end

    // reference domain: bring the echo back, one extra stage for edge detect
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            echo_sh <= '0;
        end else begin
            echo_sh <= {echo_sh[ECHO_W-2:0], pri_sh[SYNC_STAGES-1]};
        end
    end

    // request always opposes the settled echo, so the loop keeps turning
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= ~echo_sh[SYNC_STAGES-1];
        end
    end

    assign beat = echo_sh[SYNC_STAGES-1] ^ echo_sh[SYNC_STAGES];

endmodule

// File: rtl/cfm_ctrl.sv
`timescale 1ns/1ps
// Reference-domain controller: source register, miss counter and guard FSM.
module cfm_ctrl
    import clk_fail_guard_pkg::*;
#(
    parameter int MISS_LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic wdt_en,
    input  logic wdt_fail,
    input  logic src_sel,
    input  logic src_wr,
    input  logic fail_clr,
    input  logic beat,
    input  logic pri_on_r,
    input  logic wdt_on,
    output logic want_fb,
    output logic force_fb,
    output logic fail,
    output logic evt
);
    localparam int CNT_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MISS_LIMIT - 1);

    guard_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             sel_q, sel_d;
    logic             armed, limit_hit, sw_done;
    logic             fail_q, evt_q, want_q;

    assign sel_d     = src_wr ? src_sel : sel_q;
    assign armed     = det_en && wdt_en && !wdt_fail && (sel_q == SRC_PRI);
    assign limit_hit = (cnt_q == CNT_LAST);
    assign sw_done   = (sel_q == SRC_WDT) ? wdt_on : pri_on_r;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (src_wr)      state_d = ST_SWITCH;
                else if (armed)  state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (src_wr)                     state_d = ST_SWITCH;
                else if (!armed)                state_d = ST_OFF;
                else if (!beat && limit_hit)    state_d = ST_FAILED;
            end
            ST_SWITCH: begin
                if (src_wr)                     state_d = ST_SWITCH;
                else if (sw_done || limit_hit)  state_d = ST_OFF;
            end
            ST_FAILED: begin
                if (fail_clr)                   state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register, miss counter and source register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            sel_q   <= SRC_PRI;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            if (src_wr || (state_d != state_q) || (state_q == ST_WATCH && beat)) begin
                cnt_q <= '0;
            end else if (state_q == ST_WATCH || state_q == ST_SWITCH) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            evt_q  <= 1'b0;
            want_q <= 1'b0;
        end else begin
            fail_q <= (state_d == ST_FAILED);
            evt_q  <= (state_q == ST_WATCH) && (state_d == ST_FAILED);
            want_q <= (state_d == ST_FAILED) || (sel_d == SRC_WDT);
        end
    end

    assign fail     = fail_q;
    assign force_fb = fail_q;
    assign evt      = evt_q;
    assign want_fb  = want_q;

endmodule

// File: rtl/cfm_clk_switch.sv
`timescale 1ns/1ps
// Break-before-make clock switch. Each side's enable is resynchronised on the
// falling edge of its own clock; a forced request clears the primary side
// asynchronously so a stopped primary cannot hold the switch.
module cfm_clk_switch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic pri_clk,
    input  logic wdt_clk,
    input  logic rst_n,
    input  logic want_fb,
    input  logic force_fb,
    output logic sys_clk,
    output logic pri_on,
    output logic wdt_on,
    output logic pri_on_r
);
    logic [SYNC_STAGES-1:0] p_sh;
    logic [SYNC_STAGES-1:0] w_sh;
    logic [SYNC_STAGES-1:0] pr_sh;
    logic                   p_clr;

    assign p_clr = !rst_n || force_fb;

    always_ff @(negedge pri_clk or posedge p_clr) begin
        if (p_clr) begin
            p_sh <= '0;
        end else begin
            p_sh <= {p_sh[SYNC_STAGES-2:0], !want_fb && !w_sh[SYNC_STAGES-1]};
        end
    end

    always_ff @(negedge wdt_clk or negedge rst_n) begin
        if (!rst_n) begin
            w_sh <= '0;
        end else begin
            w_sh <= {w_sh[SYNC_STAGES-2:0], want_fb && !p_sh[SYNC_STAGES-1]};
        end
    end

    // primary-side enable seen in the reference domain (switch completion)
    always_ff @(posedge wdt_clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_sh <= '0;
        end else begin
            pr_sh <= {pr_sh[SYNC_STAGES-2:0], p_sh[SYNC_STAGES-1]};
        end
    end

    assign pri_on   = p_sh[SYNC_STAGES-1];
    assign wdt_on   = w_sh[SYNC_STAGES-1];
    assign pri_on_r = pr_sh[SYNC_STAGES-1];
    assign sys_clk  = (pri_clk & pri_on) | (wdt_clk & wdt_on);

endmodule

// File: rtl/clk_fail_guard.sv
`timescale 1ns/1ps
module clk_fail_guard #(
    parameter int MISS_LIMIT  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic pri_clk_i,
    input  logic wdt_clk_i,
    input  logic rst_ni,
    input  logic wdt_en_i,
    input  logic det_en_i,
    input  logic wdt_fail_i,
    input  logic src_sel_i,
    input  logic src_wr_i,
    input  logic fail_clr_i,
    output logic sys_clk_o,
    output logic fail_o,
    output logic fail_evt_o
);
    logic beat;
    logic want_fb;
    logic force_fb;
    logic mux_pri_on;
    logic mux_wdt_on;
    logic mux_pri_on_r;

    cfm_heartbeat #(.SYNC_STAGES(SYNC_STAGES)) u_beat (
        .pri_clk (pri_clk_i),
        .ref_clk (wdt_clk_i),
        .rst_n   (rst_ni),
        .beat    (beat)
    );

    cfm_ctrl #(.MISS_LIMIT(MISS_LIMIT)) u_ctrl (
        .clk      (wdt_clk_i),
        .rst_n    (rst_ni),
        .det_en   (det_en_i),
        .wdt_en   (wdt_en_i),
        .wdt_fail (wdt_fail_i),
        .src_sel  (src_sel_i),
        .src_wr   (src_wr_i),
        .fail_clr (fail_clr_i),
        .beat     (beat),
        .pri_on_r (mux_pri_on_r),
        .wdt_on   (mux_wdt_on),
        .want_fb  (want_fb),
        .force_fb (force_fb),
        .fail     (fail_o),
        .evt      (fail_evt_o)
    );

    cfm_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .pri_clk  (pri_clk_i),
        .wdt_clk  (wdt_clk_i),
        .rst_n    (rst_ni),
        .want_fb  (want_fb),
        .force_fb (force_fb),
        .sys_clk  (sys_clk_o),
        .pri_on   (mux_pri_on),
        .wdt_on   (mux_wdt_on),
        .pri_on_r (mux_pri_on_r)
    );

endmodule

// File: rtl/clk_fail_guard_chk.sv
`timescale 1ns/1ps
module clk_fail_guard_chk (
    input logic wdt_clk,
    input logic rst_n,
    input logic det_en,
    input logic wdt_en,
    input logic wdt_fail,
    input logic fail_clr,
    input logic fail,
    input logic evt,
    input logic pri_on,
    input logic wdt_on
);
    assert_evt_single_R4: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        evt |=> !evt);

    assert_evt_on_rise_R4: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        $rose(fail) |-> evt);

    assert_fail_sticky_R6: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        (fail && !fail_clr) |=> fail);

    assert_forced_off_pri_R5: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        fail |-> !pri_on);

    assert_need_detect_R7: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        $rose(fail) |-> $past(det_en));

    assert_need_wdt_osc_R8: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        $rose(fail) |-> $past(wdt_en));

    assert_no_after_wdt_fail_R10: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        $rose(fail) |-> !$past(wdt_fail));

    assert_switch_exclusive_R11: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        $onehot0({pri_on, wdt_on}));

endmodule

bind clk_fail_guard clk_fail_guard_chk u_chk (
    .wdt_clk  (wdt_clk_i),
    .rst_n    (rst_ni),
    .det_en   (det_en_i),
    .wdt_en   (wdt_en_i),
    .wdt_fail (wdt_fail_i),
    .fail_clr (fail_clr_i),
    .fail     (fail_o),
    .evt      (fail_evt_o),
    .pri_on   (mux_pri_on),
    .wdt_on   (mux_wdt_on)
);

// File: tb/test_clk_fail_guard.sv
`timescale 1ns/1ps
module test_clk_fail_guard;
    localparam int LIMIT = 12;

    logic pri_clk = 1'b0;
    logic wdt_clk = 1'b0;
    logic pri_run = 1'b1;
    logic rst_n = 1'b0;
    logic wdt_en = 1'b1, det_en = 1'b0, wdt_fail = 1'b0;
    logic src_sel = 1'b0, src_wr = 1'b0, fail_clr = 1'b0;
    logic sys_clk, fail, evt;

    int checks = 0, fails = 0, evt_cnt = 0, glitches = 0;
    bit rst_done = 1'b0;
    realtime last_t = 0.0;

    clk_fail_guard #(.MISS_LIMIT(LIMIT)) i_clk_fail_guard (
        .pri_clk_i (pri_clk), .wdt_clk_i (wdt_clk), .rst_ni (rst_n),
        .wdt_en_i (wdt_en), .det_en_i (det_en), .wdt_fail_i (wdt_fail),
        .src_sel_i (src_sel), .src_wr_i (src_wr), .fail_clr_i (fail_clr),
        .sys_clk_o (sys_clk), .fail_o (fail), .fail_evt_o (evt)
    );

    // 125 MHz primary clock, held low while stopped; slower reference clock
    always #4 pri_clk = pri_run ? ~pri_clk : 1'b0;
    always #19 wdt_clk = ~wdt_clk;

    always @(negedge wdt_clk) if (evt === 1'b1) evt_cnt++;

    always @(sys_clk) begin
        if (rst_done && last_t > 0.0 && ($realtime - last_t) < 3.5) glitches++;
        last_t = $realtime;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge wdt_clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic follow(input bit to_wdt, input string tag);
        int bad = 0;
        if (!to_wdt) begin
            repeat (8) begin
                @(posedge pri_clk); #2; if (sys_clk !== 1'b1) bad++;
                @(negedge pri_clk); #2; if (sys_clk !== 1'b0) bad++;
            end
        end else begin
            repeat (4) begin
                @(posedge wdt_clk); #9; if (sys_clk !== 1'b1) bad++;
                @(negedge wdt_clk); #9; if (sys_clk !== 1'b0) bad++;
            end
        end
        chk(tag, bad, 0);
    endtask

    task automatic write_src(input logic v);
        tick(1); src_sel = v; src_wr = 1'b1;
        tick(1); src_wr = 1'b0;
    endtask

    task automatic clear_fail();
        tick(1); fail_clr = 1'b1;
        tick(1); fail_clr = 1'b0;
    endtask

    function automatic int exp_fail(bit d, bit w, bit wf, int len);
        return (d && w && !wf && len >= 30) ? 1 : 0;
    endfunction

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int ev0;
        void'($urandom(32'd4242));
        tick(5);
        chk("R1 fail in reset", int'(fail), 0);
        chk("R1 evt in reset", int'(evt), 0);
        rst_n = 1'b1;
        rst_done = 1'b1;
        tick(12);
        chk("R1 fail after reset", int'(fail), 0);
        follow(1'b0, "R1 sys follows primary");

        // armed, healthy
        det_en = 1'b1;
        tick(60);
        chk("R2 healthy no fail", int'(fail), 0);

        // short pause
        pri_run = 1'b0; tick(3); pri_run = 1'b1; tick(30);
        chk("R12 short pause no fail", int'(fail), 0);

        // real stop
        ev0 = evt_cnt;
        tick(1); pri_run = 1'b0;
        tick(LIMIT - 2);
        chk("R3 not before limit", int'(fail), 0);
        tick(14);
        chk("R3 fail after stop", int'(fail), 1);
        chk("R4 one event", evt_cnt - ev0, 1);
        follow(1'b1, "R5 forced to watchdog clock");
        tick(20);
        chk("R6 fail sticky", int'(fail), 1);
        chk("R4 no repeat event", evt_cnt - ev0, 1);
        pri_run = 1'b1; tick(6);
        follow(1'b1, "R5 stays on watchdog after resume");

        // clear, then detection disabled
        det_en = 1'b0;
        clear_fail(); tick(12);
        chk("R6 cleared", int'(fail), 0);
        follow(1'b0, "R6 back to primary");
        pri_run = 1'b0; tick(40);
        chk("R7 no detect when disabled", int'(fail), 0);
        pri_run = 1'b1; tick(6);

        // watchdog oscillator disabled
        det_en = 1'b1; wdt_en = 1'b0;
        tick(4); pri_run = 1'b0; tick(40);
        chk("R8 no detect without wdt osc", int'(fail), 0);
        pri_run = 1'b1; tick(6);
        follow(1'b0, "R8 clock not moved");
        wdt_en = 1'b1;

        // watchdog oscillator failure flagged
        wdt_fail = 1'b1;
        tick(4); pri_run = 1'b0; tick(40);
        chk("R10 no detect after wdt fail", int'(fail), 0);
        pri_run = 1'b1; tick(6);
        wdt_fail = 1'b0;

        // source switching
        det_en = 1'b0;
        write_src(1'b1); tick(12);
        follow(1'b1, "R11 switched to watchdog source");
        det_en = 1'b1;
        tick(4); pri_run = 1'b0; tick(40);
        chk("R9 no detect on watchdog source", int'(fail), 0);
        pri_run = 1'b1; tick(6);
        det_en = 1'b0;
        write_src(1'b0); tick(12);
        follow(1'b0, "R11 switched back to primary");

        // constrained random mix
        for (int it = 0; it < 12; it++) begin
            bit d, w, wf;
            int len, e;
            d  = ($urandom % 4) != 0;
            w  = ($urandom % 4) != 0;
            wf = ($urandom % 4) == 0;
            len = ($urandom % 2) ? 40 : (2 + int'($urandom % 3));
            e = exp_fail(d, w, wf, len);
            det_en = d; wdt_en = w; wdt_fail = wf;
            tick(4);
            ev0 = evt_cnt;
            pri_run = 1'b0; tick(len); pri_run = 1'b1; tick(20);
            chk(len >= 30 ? "R3 random stop" : "R12 random pause", int'(fail), e);
            chk("R4 random event count", evt_cnt - ev0, e);
            if (e == 1) follow(1'b1, "R5 random forced clock");
            clear_fail(); tick(12);
            chk("R6 random clear", int'(fail), 0);
        end

        chk("R11 no glitch on system clock", glitches, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule